// File: doc/BRIEF.md
# Video clock divider tap selector

This block turns one of several source clock-enable streams into the pixel-rate enables for a video output path. A 3-bit source select picks one of eight source tick inputs. Source 0 is the output of an upstream fractional divider. A programmable pre-divider counts N selected ticks for each pre-divided pulse. A shared phase counter then turns that pulse stream into five taps: divide by 1, 2, 4, 6 and 12. Each tap has its own gate.

Three consumers each pick a tap with a 4-bit encoded index: an interlaced encoder, a progressive encoder and an HDMI transmitter pixel clock. Each consumer also has its own output gate. A fourth output serves a DAC and follows the divide-by-1 tap through its own gate. A master enable qualifies every output. Every output is a one-cycle clock-enable pulse in the `clk` domain. Nothing in this block muxes or switches a real clock.

Configuration arrives as 32-bit word writes on a plain write port. A write takes effect on the clock edge that samples it.

Top module: `vclk_tap_sel`

## Requirements
- R1: After `rst_n` is released, every output is 0 and `sel_err` is 0. All register fields reset to 0.
- R2: Addresses are 0 = control, 1 = divider, 2 = output gates, 3 = transmitter select.
  - Control bits 18:16 pick which `src_tick` bit feeds the pre-divider.
  - Divider bits 7:0 hold N-1, and the pre-divider emits one pulse per N selected source ticks.
  - No pulses are produced unless divider bit 16 (divider enable) is set.
- R3: Selector encoding 0, 1, 2, 3, 4 chooses the /1, /2, /4, /6 or /12 tap of the pre-divided stream. A consumer's pulses are then spaced N×ratio selected source ticks apart.
- R4: Control bits 0 to 4 gate the /1, /2, /4, /6 and /12 taps respectively. A consumer whose selected tap gate is clear emits no pulse.
- R5: Control bit 19 is the master enable. While it is clear, no output pulses.
- R6: Gate word bits act as per-output gates: bit 0 for the interlaced encoder, bit 2 for the progressive encoder, bit 4 for the DAC and bit 5 for the transmitter. Clearing one gate silences only that output.
- R7: The selector fields are located as follows:
  - interlaced encoder: divider bits 31:28
  - progressive encoder: divider bits 27:24
  - transmitter: bits 19:16 of the transmitter select word
- R8: Selector values 5 to 15 are reserved. They give no pulses on that consumer and set `sel_err`, which stays set until `rst_n`.
- R9: While control bit 15 (soft reset) or divider bit 17 (divider reset) is set, all counters are held at zero and nothing pulses.
  - After release, the pre-divided pulse follows the Nth selected source tick.
  - Each output rises one clock after that pulse.
- R10: The first pre-divided pulse after a counter clear is phase zero for all taps. Every consumer fires on it, whatever tap it selects.
- R11: `dac_tick` follows the /1 tap. It requires the /1 tap gate, the DAC gate and the master enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 8 | Source clock-enable streams, one per source select value |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| enc_i_tick | output | 1 | Interlaced encoder clock enable |
| enc_p_tick | output | 1 | Progressive encoder clock enable |
| tx_tick | output | 1 | Transmitter pixel clock enable |
| dac_tick | output | 1 | DAC clock enable |
| sel_err | output | 1 | Sticky reserved-selector flag |

## Verification
Two of the block's functions can act in the same cycle:
- a register write that changes a tap gate, an output gate or a selector, and
- a tap pulse already on its way to an output register.

The bench provokes this by writing gates and selectors while outputs are running. It judges the result by pulse counts over fixed windows: zero pulses after disabling, and pulses again after enabling.

A counter clear can also land on the same edge as a pre-divided pulse. The bench releases soft reset and divider reset and counts edges to the first pulse. It also checks that the /1, /6 and /12 consumers all fire in that first cycle.

// File: rtl/vclk_tap_pkg.sv
package vclk_tap_pkg;

  localparam int NUM_TAPS  = 5;
  localparam int PHASE_MOD = 12;
  localparam int DIV_W     = 8;
  localparam int SEL_W     = 4;
  localparam int SRC_W     = 3;
  localparam int NUM_CONS  = 3;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_DIV   = 2'd1,
    ADDR_GATE  = 2'd2,
    ADDR_TXSEL = 2'd3
  } cfg_addr_e;

  typedef struct packed {
    logic                master_en;
    logic [SRC_W-1:0]    src_sel;
    logic                soft_rst;
    logic [NUM_TAPS-1:0] tap_gate;
  } ctrl_t;

  typedef struct packed {
    logic [SEL_W-1:0] sel_i;
    logic [SEL_W-1:0] sel_p;
    logic             div_rst;
    logic             div_en;
    logic [DIV_W-1:0] div_m1;
  } divcfg_t;

  typedef struct packed {
    logic tx;
    logic dac;
    logic enc_p;
    logic enc_i;
  } gate_t;

  function automatic int tap_ratio(input int idx);
    case (idx)
      0:       return 1;
      1:       return 2;
      2:       return 4;
      3:       return 6;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/vclk_cfg_regs.sv
module vclk_cfg_regs
  import vclk_tap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output ctrl_t       ctrl_o,
  output divcfg_t     div_o,
  output gate_t       gate_o,
  output logic [SEL_W-1:0] tx_sel_o
);

  localparam int CTRL_GATE_LSB = 0;
  localparam int CTRL_SRST_BIT = 15;
  localparam int CTRL_SRC_LSB  = 16;
  localparam int CTRL_MEN_BIT  = 19;
  localparam int DIV_EN_BIT    = 16;
  localparam int DIV_RST_BIT   = 17;
  localparam int DIV_SELP_LSB  = 24;
  localparam int DIV_SELI_LSB  = 28;
  localparam int GATE_ENCI_BIT = 0;
  localparam int GATE_ENCP_BIT = 2;
  localparam int GATE_DAC_BIT  = 4;
  localparam int GATE_TX_BIT   = 5;
  localparam int TXSEL_LSB     = 16;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o   <= '0;
      div_o    <= '0;
      gate_o   <= '0;
      tx_sel_o <= '0;
    end else if (we) begin
      case (cfg_addr_e'(addr))
        ADDR_CTRL: begin
          ctrl_o.tap_gate  <= wdata[CTRL_GATE_LSB +: NUM_TAPS];
          ctrl_o.soft_rst  <= wdata[CTRL_SRST_BIT];
          ctrl_o.src_sel   <= wdata[CTRL_SRC_LSB +: SRC_W];
          ctrl_o.master_en <= wdata[CTRL_MEN_BIT];
        end
        ADDR_DIV: begin
          div_o.div_m1  <= wdata[0 +: DIV_W];
          div_o.div_en  <= wdata[DIV_EN_BIT];
          div_o.div_rst <= wdata[DIV_RST_BIT];
          div_o.sel_p   <= wdata[DIV_SELP_LSB +: SEL_W];
          div_o.sel_i   <= wdata[DIV_SELI_LSB +: SEL_W];
        end
        ADDR_GATE: begin
          gate_o.enc_i <= wdata[GATE_ENCI_BIT];
          gate_o.enc_p <= wdata[GATE_ENCP_BIT];
          gate_o.dac   <= wdata[GATE_DAC_BIT];
          gate_o.tx    <= wdata[GATE_TX_BIT];
        end
        default: tx_sel_o <= wdata[TXSEL_LSB +: SEL_W];
      endcase
    end
  end

endmodule

// File: rtl/vclk_prediv.sv
module vclk_prediv #(
  parameter int SRC_W = 3,
  parameter int DIV_W = 8,
  localparam int NUM_SRC = 1 << SRC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               run,
  input  logic [SRC_W-1:0]   src_sel,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [DIV_W-1:0]   div_m1,
  output logic               pre_tick
);

  logic [DIV_W-1:0] cnt;
  logic             hit;

  assign hit = run && src_tick[src_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      pre_tick <= 1'b0;
    end else if (clr) begin
      cnt      <= '0;
      pre_tick <= 1'b0;
    end else begin
      pre_tick <= 1'b0;
      if (hit) begin
        if (cnt >= div_m1) begin
          cnt      <= '0;
          pre_tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vclk_tap_bank.sv
module vclk_tap_bank
  import vclk_tap_pkg::*;
#(
  parameter int NTAPS = NUM_TAPS,
  parameter int MODV  = PHASE_MOD,
  localparam int PH_W = $clog2(MODV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             pre_tick,
  output logic [NTAPS-1:0] taps
);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (clr) begin
      phase <= '0;
    end else if (pre_tick) begin
      if (phase == PH_W'(MODV - 1)) phase <= '0;
      else                          phase <= phase + 1'b1;
    end
  end

  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    localparam int RATIO = tap_ratio(g);
    assign taps[g] = pre_tick && ((32'(phase) % RATIO) == 0);
  end

endmodule

// File: rtl/vclk_route.sv
module vclk_route #(
  parameter int SEL_W = 4,
  parameter int NTAPS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTAPS-1:0] taps,
  input  logic [NTAPS-1:0] tap_gate,
  input  logic             master_en,
  input  logic             out_gate,
  input  logic [SEL_W-1:0] sel,
  output logic             tick_o,
  output logic             bad_o
);

  logic [NTAPS-1:0] live;
  logic             hit;

  assign live  = taps & tap_gate;
  assign bad_o = (sel >= SEL_W'(NTAPS));

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NTAPS; i++) begin
      if (sel == SEL_W'(i)) hit = live[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_o <= 1'b0;
    else        tick_o <= hit && master_en && out_gate;
  end

endmodule

// File: rtl/vclk_tap_sel.sv
module vclk_tap_sel
  import vclk_tap_pkg::*;
#(
  localparam int NUM_SRC = 1 << SRC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic               enc_i_tick,
  output logic               enc_p_tick,
  output logic               tx_tick,
  output logic               dac_tick,
  output logic               sel_err
);

  ctrl_t            ctrl_q;
  divcfg_t          div_q;
  gate_t            gate_q;
  logic [SEL_W-1:0] tx_sel_q;
  logic             clr;
  logic             pre_tick;
  logic [NUM_TAPS-1:0] taps;

  logic [SEL_W-1:0]    cons_sel  [NUM_CONS];
  logic [NUM_CONS-1:0] cons_gate;
  logic [NUM_CONS-1:0] cons_tick;
  logic [NUM_CONS-1:0] cons_bad;

  vclk_cfg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .ctrl_o   (ctrl_q),
    .div_o    (div_q),
    .gate_o   (gate_q),
    .tx_sel_o (tx_sel_q)
  );

  assign clr = ctrl_q.soft_rst | div_q.div_rst;

  vclk_prediv #(.SRC_W(SRC_W), .DIV_W(DIV_W)) u_prediv (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .run      (div_q.div_en),
    .src_sel  (ctrl_q.src_sel),
    .src_tick (src_tick),
    .div_m1   (div_q.div_m1),
    .pre_tick (pre_tick)
  );

  vclk_tap_bank #(.NTAPS(NUM_TAPS), .MODV(PHASE_MOD)) u_taps (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .pre_tick (pre_tick),
    .taps     (taps)
  );

  assign cons_sel[0] = div_q.sel_i;
  assign cons_sel[1] = div_q.sel_p;
  assign cons_sel[2] = tx_sel_q;
  assign cons_gate   = {gate_q.tx, gate_q.enc_p, gate_q.enc_i};

  for (genvar c = 0; c < NUM_CONS; c++) begin : g_cons
    vclk_route #(.SEL_W(SEL_W), .NTAPS(NUM_TAPS)) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .taps      (taps),
      .tap_gate  (ctrl_q.tap_gate),
      .master_en (ctrl_q.master_en),
      .out_gate  (cons_gate[c]),
      .sel       (cons_sel[c]),
      .tick_o    (cons_tick[c]),
      .bad_o     (cons_bad[c])
    );
  end

  assign enc_i_tick = cons_tick[0];
  assign enc_p_tick = cons_tick[1];
  assign tx_tick    = cons_tick[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_tick <= 1'b0;
      sel_err  <= 1'b0;
    end else begin
      dac_tick <= taps[0] && ctrl_q.tap_gate[0] && gate_q.dac && ctrl_q.master_en;
      sel_err  <= sel_err | (|cons_bad);
    end
  end

endmodule

// File: rtl/vclk_tap_sel_chk.sv
module vclk_tap_sel_chk
  import vclk_tap_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                master,
  input logic                clr,
  input logic                pre_tick,
  input logic [NUM_TAPS-1:0] taps,
  input logic [SEL_W-1:0]    sel_i,
  input logic [DIV_W-1:0]    div_m1,
  input logic                enc_i_tick,
  input logic                enc_p_tick,
  input logic                tx_tick,
  input logic                dac_tick,
  input logic                sel_err
);

  // R5
  master_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master |=> !(enc_i_tick || enc_p_tick || tx_tick || dac_tick));

  // R8
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i >= SEL_W'(NUM_TAPS)) |=> !enc_i_tick);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |=> sel_err);

  // R9
  clear_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pre_tick);

  // R2
  prediv_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_tick && div_m1 != '0 && !clr) |=> !pre_tick);

  // R10
  aligned_taps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taps[NUM_TAPS-1] |-> (&taps));

  // R11
  dac_follows_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_tick |-> $past(taps[0]));

endmodule

bind vclk_tap_sel vclk_tap_sel_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .master     (ctrl_q.master_en),
  .clr        (clr),
  .pre_tick   (pre_tick),
  .taps       (taps),
  .sel_i      (div_q.sel_i),
  .div_m1     (div_q.div_m1),
  .enc_i_tick (enc_i_tick),
  .enc_p_tick (enc_p_tick),
  .tx_tick    (tx_tick),
  .dac_tick   (dac_tick),
  .sel_err    (sel_err)
);

// File: tb/test_vclk_tap_sel.sv
module test_vclk_tap_sel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_tick = 8'h01;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        enc_i_tick, enc_p_tick, tx_tick, dac_tick, sel_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] w_ctrl, w_div, w_gate, w_tx;

  always #5 clk = ~clk;

  always @(negedge clk) src_tick[1] <= ~src_tick[1];

  vclk_tap_sel i_vclk_tap_sel (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .enc_i_tick(enc_i_tick), .enc_p_tick(enc_p_tick), .tx_tick(tx_tick),
    .dac_tick(dac_tick), .sel_err(sel_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ratio(input int s);
    case (s)
      0: return 1; 1: return 2; 2: return 4; 3: return 6; default: return 12;
    endcase
  endfunction

  function automatic logic out_bit(input int w);
    case (w)
      0: return enc_i_tick; 1: return enc_p_tick; 2: return tx_tick; default: return dac_tick;
    endcase
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push_all();
    wr(2'd0, w_ctrl); wr(2'd1, w_div); wr(2'd2, w_gate); wr(2'd3, w_tx);
  endtask

  task automatic set_sels(input int si, input int sp, input int st);
    w_div[31:28] = 4'(si); w_div[27:24] = 4'(sp); w_tx[19:16] = 4'(st);
    wr(2'd1, w_div); wr(2'd3, w_tx);
  endtask

  task automatic set_div(input int n, input int src);
    w_ctrl[15] = 1'b1; wr(2'd0, w_ctrl);
    w_ctrl[18:16] = 3'(src); w_div[7:0] = 8'(n - 1); w_div[16] = 1'b1;
    wr(2'd1, w_div);
    w_ctrl[15] = 1'b0; wr(2'd0, w_ctrl);
  endtask

  task automatic count_pulses(input int w, input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (out_bit(w)) n++;
    end
  endtask

  task automatic spacing(input int w, input int exp, input string req);
    int last = -1, iv = 0, bad = 0, cyc = 0;
    while (iv < 3 && cyc < 4 * exp + 40) begin
      @(negedge clk); cyc++;
      if (out_bit(w)) begin
        if (last >= 0) begin
          if (cyc - last != exp) bad = cyc - last;
          iv++;
        end
        last = cyc;
      end
    end
    check(iv == 3 && bad == 0, req, (iv == 3) ? bad : -1, exp);
  endtask

  task automatic t_reset();
    check(!enc_i_tick && !enc_p_tick && !tx_tick && !dac_tick, "R1 outputs", 1, 0);
    check(!sel_err, "R1 sel_err", int'(sel_err), 0);
  endtask

  task automatic t_spacing();
    int ns[3] = '{1, 3, 5};
    foreach (ns[k]) begin
      set_div(ns[k], 0);
      for (int s = 0; s < 5; s++) begin
        set_sels(s, (s + 1) % 5, (s + 2) % 5);
        spacing(0, ns[k] * ratio(s), "R3 R7 interlaced");
        spacing(1, ns[k] * ratio((s + 1) % 5), "R3 R7 progressive");
        spacing(2, ns[k] * ratio((s + 2) % 5), "R3 R7 transmitter");
      end
      spacing(3, ns[k], "R11 dac");
    end
  endtask

  task automatic t_source();
    int n;
    set_div(2, 1);
    set_sels(2, 0, 4);
    spacing(0, 16, "R2 source 1 /4");
    spacing(1, 4, "R2 source 1 /1");
    set_div(3, 2);
    count_pulses(0, 100, n);
    check(n == 0, "R2 idle source", n, 0);
    set_div(2, 0);
    w_div[16] = 1'b0; wr(2'd1, w_div);
    repeat (3) @(negedge clk);
    count_pulses(1, 60, n);
    check(n == 0, "R2 divider disabled", n, 0);
    w_div[16] = 1'b1; wr(2'd1, w_div);
  endtask

  task automatic t_gating();
    int n;
    set_div(2, 0);
    set_sels(1, 3, 0);
    w_ctrl[1] = 1'b0; wr(2'd0, w_ctrl);
    count_pulses(0, 40, n);
    check(n == 0, "R4 tap gate /2 off", n, 0);
    count_pulses(1, 40, n);
    check(n > 0, "R4 other tap still live", n, 1);
    w_ctrl[1] = 1'b1; wr(2'd0, w_ctrl);
    spacing(0, 4, "R4 tap gate restored");
    w_gate[2] = 1'b0; wr(2'd2, w_gate);
    count_pulses(1, 40, n);
    check(n == 0, "R6 progressive gate off", n, 0);
    count_pulses(0, 40, n);
    check(n > 0, "R6 interlaced unaffected", n, 1);
    w_gate[2] = 1'b1; wr(2'd2, w_gate);
    w_gate[5] = 1'b0; wr(2'd2, w_gate);
    count_pulses(2, 40, n);
    check(n == 0, "R6 transmitter gate off", n, 0);
    w_gate[5] = 1'b1; wr(2'd2, w_gate);
    w_gate[4] = 1'b0; wr(2'd2, w_gate);
    count_pulses(3, 40, n);
    check(n == 0, "R6 dac gate off", n, 0);
    w_gate[4] = 1'b1; wr(2'd2, w_gate);
    w_ctrl[19] = 1'b0; wr(2'd0, w_ctrl);
    count_pulses(2, 40, n);
    check(n == 0, "R5 master off", n, 0);
    w_ctrl[19] = 1'b1; wr(2'd0, w_ctrl);
    spacing(2, 2, "R5 master restored");
  endtask

  task automatic t_reserved();
    int n;
    set_div(1, 0);
    set_sels(7, 0, 0);
    count_pulses(0, 30, n);
    check(n == 0, "R8 reserved quiet", n, 0);
    check(sel_err == 1'b1, "R8 error set", int'(sel_err), 1);
    set_sels(0, 0, 0);
    repeat (3) @(negedge clk);
    check(sel_err == 1'b1, "R8 error sticky", int'(sel_err), 1);
    spacing(0, 1, "R8 valid after reserved");
  endtask

  task automatic t_clear(input bit use_div);
    int n = 0, k = 0;
    bit seen = 0, all = 0;
    set_div(4, 0);
    set_sels(0, 3, 4);
    if (use_div) begin w_div[17] = 1'b1; wr(2'd1, w_div); end
    else         begin w_ctrl[15] = 1'b1; wr(2'd0, w_ctrl); end
    count_pulses(0, 30, n);
    check(n == 0, "R9 held in clear", n, 0);
    if (use_div) begin w_div[17] = 1'b0; wr(2'd1, w_div); end
    else         begin w_ctrl[15] = 1'b0; wr(2'd0, w_ctrl); end
    while (!seen && k < 40) begin
      @(negedge clk); k++;
      if (enc_i_tick) begin
        seen = 1;
        all = enc_p_tick && tx_tick;
      end
    end
    check(seen && k == 5, use_div ? "R9 divider reset latency" : "R9 soft reset latency", k, 5);
    check(all, "R10 taps aligned at first pulse", int'(all), 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    w_ctrl = (32'd1 << 19) | 32'h1F;
    w_div  = 32'h0001_0000;
    w_gate = 32'h35;
    w_tx   = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    push_all();
    t_spacing();
    t_source();
    t_gating();
    t_clear(1'b0);
    t_clear(1'b1);
    t_reserved();
    finish_run();
  end

endmodule